// File: doc/BRIEF.md
# Log-Stage Barrel Shifter

This block is a purely combinational shifter for a 32-bit datapath. It moves operand A left or right by 0 to 31 bit positions in a single pass, under a 2-bit mode code. Three modes are defined:

- a logical left shift, which fills with zeros;
- a logical right shift, which fills with zeros;
- an arithmetic right shift, which replicates the operand's sign bit into the vacated positions.

The shift distance comes from the low bits of a second operand, B, so the block can sit directly beside an adder that shares the same two operand buses.

Internally there is one left-shifting cascade of power-of-two stages, each stage enabled by one count bit. Right shifts reuse that cascade. The data word is mirrored on the way in, shifted left, and mirrored again on the way out. The fill bit fed to the cascade is zero, except in arithmetic-right mode, where it is the operand's top bit.

Top module: `log_shifter`

## Requirements
- R1: With mode 2'b00 (logical left), result equals opd_a shifted toward the MSB by n positions, where n is the count, and the n lowest result bits are 0.
- R2: With mode 2'b01 (logical right), result equals opd_a shifted toward the LSB by n positions, and the n highest result bits are 0.
- R3: With mode 2'b11 (arithmetic right), result equals opd_a shifted toward the LSB by n positions, and the n highest result bits all equal opd_a[31].
- R4: Mode 2'b10 is not a defined operation and gives exactly the logical-left result of R1, never sign fill.
- R5: The count n is opd_b[4:0], so values 0 to 31 are possible, and opd_b[31:5] has no effect on result.
- R6: When n is 0, result equals opd_a in every mode.
- R7: Every count from 1 to 31 gives the correct result in each mode, including the largest distance of 31. At n = 31 a left shift keeps only opd_a[0], at the MSB, and a right shift keeps only opd_a[31], at the LSB.
- R8: result is a combinational function of opd_a, opd_b and mode. It settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | Data word to be shifted |
| opd_b | input | 32 | Second operand; bits [4:0] give the shift distance, the rest are ignored |
| mode | input | 2 | Bit 0 selects direction (0 left, 1 right); bit 1 enables sign fill on right shifts |
| result | output | 32 | Shifted word |

## Verification
The in-RTL checks assume that the three inputs are stable whenever the combinational result is evaluated, and that mode is a 2-bit value with no X or Z bits. The bench meets this by changing every input together, away from the sampling point, and by drawing mode only from the four legal 2-bit codes. Random operands also carry random upper bits in opd_b. This exercises the assumption that only the low five bits define the distance while the upper bits may hold anything. Directed sweeps cover every count in each defined mode, with operands whose top bit is both set and clear, so that sign fill is observed in both directions.

// File: rtl/shifter_pkg.sv
// Package: shared mode encoding for the log-stage shifter.
// Assumes: the mode code is two bits; bit 0 is direction, bit 1 sign fill.
package shifter_pkg;

    typedef enum logic [1:0] {
        SH_LEFT      = 2'b00,
        SH_RIGHT_LOG = 2'b01,
        SH_UNDEF     = 2'b10,
        SH_RIGHT_ARI = 2'b11
    } shift_mode_e;

    localparam int DIR_BIT  = 0;
    localparam int SIGN_BIT = 1;

endpackage

// File: rtl/bit_mirror.sv
// Module: bit_mirror
// Reverses the bit order of a word: out[i] = in[W-1-i].
// Assumes: nothing beyond W >= 1; pure wiring, no logic depth.
module bit_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // One wire per bit position, crossing the word end to end.
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/shift_stage.sv
// Module: shift_stage
// One layer of the cascade: when en is set, moves the word DIST places
// toward the MSB and feeds fill into the DIST freed low positions;
// otherwise passes the word through.
// Assumes: 0 < DIST < W.
module shift_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         fill,
    input  logic         en,
    output logic [W-1:0] dout
);

    logic [W-1:0] moved;

    // Shifted candidate, with fill replicated into the low positions.
    assign moved = {din[W-1-DIST:0], {DIST{fill}}};

    // Stage select: one 2:1 multiplexer layer per bit.
    always_comb begin
        dout = en ? moved : din;
    end

endmodule

// File: rtl/left_cascade.sv
// Module: left_cascade
// Chain of power-of-two shift_stage layers (W/2 down to 1), each enabled
// by one count bit, giving any left shift from 0 to W-1 positions.
// Assumes: W is a power of two, so CNT_W bits address exactly W distances.
module left_cascade #(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic             fill,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     dout
);

    logic [W-1:0] chain [0:CNT_W];

    assign chain[0] = din;

    // Largest distance first; layer k is driven by count bit CNT_W-1-k.
    for (genvar k = 0; k < CNT_W; k++) begin : g_layer
        localparam int BIT_IDX = CNT_W - 1 - k;
        shift_stage #(
            .W    (W),
            .DIST (1 << BIT_IDX)
        ) u_stage (
            .din  (chain[k]),
            .fill (fill),
            .en   (cnt[BIT_IDX]),
            .dout (chain[k+1])
        );
    end

    assign dout = chain[CNT_W];

endmodule

// File: rtl/log_shifter.sv
// Module: log_shifter (top)
// Combinational shifter with logical left, logical right and arithmetic
// right modes. Right shifts mirror the data, run it through the single
// left cascade, and mirror the output back.
// Assumes: DATA_W is a power of two; inputs are stable and X-free when
// the result is evaluated. The code 2'b10 is treated as a left shift.
module log_shifter
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int MSB   = DATA_W - 1;

    logic [CNT_W-1:0]  cnt;
    logic              go_right;
    logic              fill_bit;
    logic [DATA_W-1:0] a_mirror;
    logic [DATA_W-1:0] casc_in;
    logic [DATA_W-1:0] casc_out;
    logic [DATA_W-1:0] out_mirror;
    logic              b_hi_unused;

    // Distance comes from the low bits of B only (R5).
    assign cnt         = opd_b[CNT_W-1:0];
    assign b_hi_unused = ^opd_b[DATA_W-1:CNT_W];

    // Decode direction, and the fill bit; sign fill needs both mode bits.
    always_comb begin
        go_right = mode[DIR_BIT];
        fill_bit = mode[SIGN_BIT] & mode[DIR_BIT] & opd_a[MSB];
    end

    bit_mirror #(.W(DATA_W)) u_in_mirror (
        .din  (opd_a),
        .dout (a_mirror)
    );

    // Select the natural or mirrored word as the cascade input.
    always_comb begin
        casc_in = go_right ? a_mirror : opd_a;
    end

    left_cascade #(.W(DATA_W)) u_cascade (
        .din  (casc_in),
        .fill (fill_bit),
        .cnt  (cnt),
        .dout (casc_out)
    );

    bit_mirror #(.W(DATA_W)) u_out_mirror (
        .din  (casc_out),
        .dout (out_mirror)
    );

    // Undo the mirroring for right shifts.
    always_comb begin
        result = go_right ? out_mirror : casc_out;
    end

    // ---------------- assertions ----------------
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] high_mask;

    // Masks of the positions a shift of cnt vacates, used only by checks.
    always_comb begin
        low_mask  = ~({DATA_W{1'b1}} << cnt);
        high_mask = ~({DATA_W{1'b1}} >> cnt);
    end

    // Check the output against the input word and the mode, per mode.
    always_comb begin
        if (cnt == '0) begin
            AST_ZERO_PASS: assert (result == opd_a) else $error("zero count altered data"); // R6
        end
        if (mode == SH_LEFT) begin
            AST_LEFT_ZERO_FILL: assert ((result & low_mask) == '0) else $error("left fill not zero"); // R1
            AST_LEFT_LSB_LANDS: assert (result[cnt] == opd_a[0]) else $error("left LSB misplaced"); // R7
        end
        if (mode == SH_UNDEF) begin
            AST_UNDEF_NO_SIGN: assert ((result & low_mask) == '0) else $error("undefined mode filled"); // R4
        end
        if (mode == SH_RIGHT_LOG) begin
            AST_RLOG_ZERO_FILL: assert ((result & high_mask) == '0) else $error("logical right fill not zero"); // R2
        end
        if (mode == SH_RIGHT_ARI) begin
            AST_RARI_SIGN_FILL: assert ((result & high_mask) == (opd_a[MSB] ? high_mask : '0)) else $error("sign fill wrong"); // R3
        end
        if (go_right) begin
            AST_RIGHT_MSB_LANDS: assert (result[MSB - int'(cnt)] == opd_a[MSB]) else $error("right MSB misplaced"); // R7
        end
    end

endmodule

// File: tb/log_shifter_test.sv
// Bench for log_shifter: count sweeps in every mode with directed
// operands, then seeded random stimulus, checked against a bit-level model.
module log_shifter_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic [1:0]   mode  = 2'b00;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    log_shifter #(.DATA_W(W)) uut (
        .opd_a  (opd_a),
        .opd_b  (opd_b),
        .mode   (mode),
        .result (result)
    );

    // Reference: pick each output bit from its source position or the fill.
    function automatic logic [W-1:0] expect_val(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m);
        logic [W-1:0] r;
        int n;
        logic fill;
        n    = int'(b[4:0]);
        fill = (m == 2'b11) ? a[W-1] : 1'b0;
        for (int i = 0; i < W; i++) begin
            if (m[0] == 1'b0) r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
            else              r[i] = (i + n < W)  ? a[i+n] : fill;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: a=%h b=%h mode=%b got=%h expected=%h", tag, opd_a, opd_b, mode, got, exp);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(string tag, logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m);
        @(posedge clk);
        opd_a = a;
        opd_b = b;
        mode  = m;
        @(negedge clk);
        check(tag, result, expect_val(a, b, m));
    endtask

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic [W-1:0] pats [4];
        int seed_init;
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hDEAD_BEEF;
        pats[3] = 32'h1234_5678;
        seed_init = $urandom(32'h0005_EED5);

        // Idle state with all-zero inputs: result zero (R8).
        @(negedge clk);
        check("R8 idle", result, '0);

        // Zero count passes A in all four codes (R6).
        for (int m = 0; m < 4; m++) begin
            apply("R6 zero count", 32'hA5C3_0F96, 32'hFFFF_FFE0, 2'(m));
        end

        // Full count sweeps per defined mode (R1, R2, R3, R7).
        for (int n = 0; n < W; n++) begin
            for (int p = 0; p < 4; p++) begin
                apply("R1 left sweep",  pats[p], 32'(n), 2'b00);
                apply("R2 lright sweep", pats[p], 32'(n), 2'b01);
                apply("R3 aright sweep", pats[p], 32'(n), 2'b11);
            end
        end

        // Largest distance corners (R7).
        apply("R7 left 31",   32'h0000_0001, 32'd31, 2'b00);
        apply("R7 lright 31", 32'h8000_0000, 32'd31, 2'b01);
        apply("R7 aright 31", 32'h8000_0000, 32'd31, 2'b11);

        // Undefined code matches left, no sign fill even with MSB set (R4).
        for (int n = 0; n < W; n++) begin
            apply("R4 undefined code", 32'hF000_000F, 32'(n), 2'b10);
        end

        // Upper B bits ignored: same count, different high bits (R5).
        for (int n = 0; n < W; n += 3) begin
            apply("R5 upper B ignored", 32'hC0DE_F00D, {27'h5A5A5A5, 5'(n)}, 2'b11);
            apply("R5 upper B ignored", 32'hC0DE_F00D, {27'h7FFFFFF, 5'(n)}, 2'b01);
        end

        // Seeded random mix over all four codes (R1..R5 by mode).
        for (int k = 0; k < 600; k++) begin
            ra = $urandom;
            rb = $urandom;
            apply("R5 random mix", ra, rb, 2'($urandom_range(3, 0)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule